// File: doc/BRIEF.md
# Multi-Lane Serial Flash Transaction Sequencer

This block is the master-side engine that carries out one whole serial-flash transaction over a four-line bidirectional data bus with a single active-low chip select. A transaction is requested with a one-cycle start pulse together with its settings: the command byte, the address length and value, the number of dummy clock cycles, the counts of bytes to send and to receive, and a 3-bit lane-format code. After that the engine runs its phases in fixed order. It sends the command byte, then the optional address, then the dummy cycles, then the outgoing data bytes, and finally it captures the incoming bytes.

The serial clock rate comes from a separate divider, which supplies a one-cycle `tick` at every half period of the serial clock. The engine toggles the serial clock only on ticks. It drives new output bits on falling edges and samples input bits on rising edges, so the serial clock idles low. Outgoing data bytes are pulled through a valid/ready handshake, and the engine stretches the serial clock while no byte is offered. Each received byte is presented for one cycle on `rx_valid`. Two pulses mark the end of sending and the end of receiving.

Top module: `qseq_engine`

## Requirements
- R1: The format code sets the line count of each phase. Codes 0 and 1 use one line for every phase. Code 2 puts the command and address on one line and the data on two; code 3 does the same with data on four. Code 4 puts the command on one line and the address and data on two; code 5 does the same with four. Code 6 uses two lines for every phase and code 7 uses four. While output is driven, `dq_oe` is 4'b0001, 4'b0011 or 4'b1111 for one, two or four lines.
- R2: Bytes go out most significant bit first. On one line, output is on `dq_o[0]` and input is sampled from `dq_i[1]`. On two or four lines, the highest active line (bit 1 or bit 3) carries the most significant bit of each group.
- R3: The phases run in this order: command, address, dummy, transmit data, receive data. The serial clock cycle count is 8/Lc + 8*A/La + D + 8*T/Ld + 8*R/Ld, where Lc, La and Ld are the line counts of the command, address and data phases.
- R4: `addr_mode` 0 means no address, 1 sends `addr[23:0]`, 2 sends `addr[31:0]`, and 3 behaves like 0. Address bytes go out starting with the most significant byte.
- R5: The dummy phase lasts `dummy_cycles` serial clock cycles and drives no line (`dq_oe` = 0). The receive phase also drives no line.
- R6: `tx_done` pulses once, on the falling edge that ends the last transmitted bit of the command, address or data. When `rx_count` is 0, the transaction ends right after the transmit phase.
- R7: Each received byte appears with a one-cycle `rx_valid` on the rising edge that samples its last bit. `rx_done` pulses together with the last such byte and does not pulse when `rx_count` is 0.
- R8: A start request while `busy` is high is ignored. Settings are captured only when the request is accepted.
- R9: `cs_n` falls when the request is accepted, at least one tick before the first serial clock edge. It rises one tick after the last falling edge. `busy` stays high for exactly one further tick period with `cs_n` high.
- R10: `sck` is low and `cs_n` is high whenever no transaction is running, `sck` changes only in the cycle after a tick, and `sck` is never high while `cs_n` is high.
- R11: A transmit byte is taken when `tx_valid` and `tx_ready` are both high. While `tx_ready` waits, the serial clock holds low, and the bit stream stays correct whatever the gaps in `tx_valid`.
- R12: While `rst` is high, `busy`, `sck`, `tx_ready`, `rx_valid`, `tx_done`, `rx_done` and `dq_oe` are 0 and `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-period strobe from the clock divider |
| start | input | 1 | Transaction request |
| fmt | input | 3 | Lane-format code |
| addr_mode | input | 2 | Address length select |
| addr | input | 32 | Flash address |
| opcode | input | 8 | Command byte |
| dummy_cycles | input | DUM_W | Dummy serial clock cycles |
| tx_count | input | CNT_W | Data bytes to send |
| rx_count | input | CNT_W | Data bytes to receive |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Engine takes a transmit byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| tx_done | output | 1 | All outgoing bits sent |
| rx_done | output | 1 | All incoming bytes received |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| dq_o | output | 4 | Data line output values |
| dq_oe | output | 4 | Data line output enables |
| dq_i | input | 4 | Data line input values |

## Verification
The assertions assume that `tick` comes from a free-running divider. They also assume that the receive drain accepts every `rx_valid` strobe, and that settings stay within the 3-bit and 2-bit codes. The bench meets these assumptions by construction. It generates `tick` with a fixed period of one to three cycles for each transaction. It logs each received byte in the same cycle it appears. It draws its settings with `$urandom` only inside the legal ranges, with small byte counts so that a full trace fits its record arrays. The flash model changes `dq_i` only while `sck` is low, so every sample the engine takes sees a settled value.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
    localparam int BYTE_W        = 8;
    localparam int LANE_N        = 4;
    localparam int ADR_MAX_BYTES = 4;
    localparam int ADR_W         = BYTE_W * ADR_MAX_BYTES;

    typedef logic [2:0] lane_cnt_t;   // 1, 2 or 4 active lines

    typedef enum logic [3:0] {
        PH_IDLE, PH_LEAD, PH_OPC, PH_ADR, PH_DUM,
        PH_TXF, PH_TXD, PH_RXD, PH_TAIL, PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        ADR_NONE  = 2'd0,
        ADR_THREE = 2'd1,
        ADR_FOUR  = 2'd2,
        ADR_SPARE = 2'd3
    } adr_mode_e;

    typedef struct packed {
        lane_cnt_t opc;
        lane_cnt_t adr;
        lane_cnt_t dat;
    } lane_plan_t;

    function automatic lane_plan_t plan_for(input logic [2:0] code);
        lane_plan_t p;
        p = '{opc: 3'd1, adr: 3'd1, dat: 3'd1};
        case (code)
            3'd2: p.dat = 3'd2;
            3'd3: p.dat = 3'd4;
            3'd4: begin p.adr = 3'd2; p.dat = 3'd2; end
            3'd5: begin p.adr = 3'd4; p.dat = 3'd4; end
            3'd6: p = '{opc: 3'd2, adr: 3'd2, dat: 3'd2};
            3'd7: p = '{opc: 3'd4, adr: 3'd4, dat: 3'd4};
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic [LANE_N-1:0] lane_mask(input lane_cnt_t n);
        case (n)
            3'd2:    return 4'b0011;
            3'd4:    return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    // index of the last serial clock cycle within one byte
    function automatic logic [2:0] slot_last(input lane_cnt_t n);
        case (n)
            3'd2:    return 3'd3;
            3'd4:    return 3'd1;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [2:0] adr_len(input adr_mode_e m);
        case (m)
            ADR_THREE: return 3'd3;
            ADR_FOUR:  return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    function automatic logic is_clocked(input phase_e p);
        return (p == PH_OPC) || (p == PH_ADR) || (p == PH_DUM) ||
               (p == PH_TXD) || (p == PH_RXD);
    endfunction

    function automatic logic is_drive(input phase_e p);
        return (p == PH_OPC) || (p == PH_ADR) || (p == PH_TXD);
    endfunction
endpackage

// File: rtl/qseq_fsm.sv
module qseq_fsm
    import qseq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DUM_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                start,
    input  logic [2:0]          fmt,
    input  logic [1:0]          addr_mode,
    input  logic [ADR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]   opcode,
    input  logic [DUM_W-1:0]    dummy_cycles,
    input  logic [CNT_W-1:0]    tx_count,
    input  logic [CNT_W-1:0]    rx_count,
    input  logic                tx_valid,
    input  logic [BYTE_W-1:0]   tx_data,
    output logic                tx_ready,
    output logic                busy,
    output logic                cs_n,
    output logic                sck,
    output logic                tx_done,
    output logic                rx_done,
    output phase_e              phase,
    output lane_cnt_t           lanes,
    output logic                drive,
    output logic                load_en,
    output logic [BYTE_W-1:0]   load_val,
    output logic                shift_en,
    output logic                cap_en,
    output logic                cap_last
);
    phase_e             st, nxt;
    logic               sck_q, cs_q, tx_done_q, rx_done_q;
    logic [2:0]         fmt_q;
    adr_mode_e          amode_q;
    logic [ADR_W-1:0]   adr_sh;
    logic [BYTE_W-1:0]  op_q;
    logic [DUM_W-1:0]   dum_q, slot_q;
    logic [CNT_W-1:0]   txc_q, rxc_q;
    logic [2:0]         adr_left, alen;
    lane_plan_t         plan;
    logic               rise, fall, byte_end, more_out, adr_load;

    assign plan     = plan_for(fmt_q);
    assign alen     = adr_len(amode_q);
    assign rise     = tick && is_clocked(st) && !sck_q;
    assign fall     = tick && is_clocked(st) && sck_q;
    assign byte_end = fall && (slot_q == '0);

    always_comb begin
        case (st)
            PH_OPC:         lanes = plan.opc;
            PH_ADR:         lanes = plan.adr;
            PH_TXD, PH_RXD: lanes = plan.dat;
            default:        lanes = 3'd1;
        endcase
    end

    // phase that follows a finished command / address / dummy / data phase
    always_comb begin
        nxt = PH_TAIL;
        if (st == PH_OPC && alen != 3'd0)
            nxt = PH_ADR;
        else if ((st == PH_OPC || st == PH_ADR) && dum_q != '0)
            nxt = PH_DUM;
        else if (st != PH_TXD && st != PH_RXD && txc_q != '0)
            nxt = PH_TXF;
        else if (st != PH_RXD && rxc_q != '0)
            nxt = PH_RXD;
    end

    assign more_out = (st == PH_OPC && alen != 3'd0) ||
                      (st == PH_ADR && adr_left > 3'd1) ||
                      (st != PH_TXD && txc_q != '0) ||
                      (st == PH_TXD && txc_q > CNT_W'(1));
    assign adr_load = byte_end && ((st == PH_OPC && nxt == PH_ADR) ||
                                   (st == PH_ADR && adr_left > 3'd1));

    always_comb begin
        load_en  = 1'b0;
        load_val = '0;
        if (st == PH_LEAD && tick) begin
            load_en  = 1'b1;
            load_val = op_q;
        end else if (st == PH_TXF && tx_valid) begin
            load_en  = 1'b1;
            load_val = tx_data;
        end else if (adr_load) begin
            load_en  = 1'b1;
            load_val = adr_sh[ADR_W-1 -: BYTE_W];
        end
    end

    assign shift_en = fall && (slot_q != '0);
    assign cap_en   = rise && (st == PH_RXD);
    assign cap_last = cap_en && (slot_q == '0);
    assign tx_ready = (st == PH_TXF);
    assign busy     = (st != PH_IDLE);
    assign cs_n     = cs_q;
    assign sck      = sck_q;
    assign tx_done  = tx_done_q;
    assign rx_done  = rx_done_q;
    assign phase    = st;
    assign drive    = is_drive(st);

    always_ff @(posedge clk) begin
        tx_done_q <= 1'b0;
        rx_done_q <= 1'b0;
        if (rst) begin
            st       <= PH_IDLE;
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            fmt_q    <= '0;
            amode_q  <= ADR_NONE;
            adr_sh   <= '0;
            op_q     <= '0;
            dum_q    <= '0;
            slot_q   <= '0;
            txc_q    <= '0;
            rxc_q    <= '0;
            adr_left <= '0;
        end else begin
            if (cap_last && rxc_q == CNT_W'(1))
                rx_done_q <= 1'b1;
            if (adr_load)
                adr_sh <= adr_sh << BYTE_W;
            case (st)
                PH_IDLE: if (start) begin
                    fmt_q   <= fmt;
                    amode_q <= adr_mode_e'(addr_mode);
                    adr_sh  <= (adr_mode_e'(addr_mode) == ADR_THREE) ?
                               {addr[ADR_W-BYTE_W-1:0], {BYTE_W{1'b0}}} : addr;
                    op_q    <= opcode;
                    dum_q   <= dummy_cycles;
                    txc_q   <= tx_count;
                    rxc_q   <= rx_count;
                    cs_q    <= 1'b0;
                    st      <= PH_LEAD;
                end
                PH_LEAD: if (tick) begin
                    st     <= PH_OPC;
                    slot_q <= DUM_W'(slot_last(plan.opc));
                end
                PH_TXF: if (tx_valid) begin
                    st     <= PH_TXD;
                    slot_q <= DUM_W'(slot_last(plan.dat));
                end
                PH_TAIL: if (tick) begin
                    cs_q <= 1'b1;
                    st   <= PH_GAP;
                end
                PH_GAP: if (tick) st <= PH_IDLE;
                default: if (tick) begin
                    sck_q <= ~sck_q;
                    if (sck_q) begin
                        if (slot_q != '0) begin
                            slot_q <= slot_q - 1'b1;
                        end else begin
                            if (is_drive(st) && !more_out)
                                tx_done_q <= 1'b1;
                            if (st == PH_ADR && adr_left > 3'd1) begin
                                adr_left <= adr_left - 3'd1;
                                slot_q   <= DUM_W'(slot_last(plan.adr));
                            end else if (st == PH_TXD && txc_q > CNT_W'(1)) begin
                                txc_q <= txc_q - 1'b1;
                                st    <= PH_TXF;
                            end else if (st == PH_RXD && rxc_q > CNT_W'(1)) begin
                                rxc_q  <= rxc_q - 1'b1;
                                slot_q <= DUM_W'(slot_last(plan.dat));
                            end else begin
                                if (st == PH_TXD) txc_q <= '0;
                                if (st == PH_RXD) rxc_q <= '0;
                                st <= nxt;
                                case (nxt)
                                    PH_ADR: begin
                                        adr_left <= alen;
                                        slot_q   <= DUM_W'(slot_last(plan.adr));
                                    end
                                    PH_DUM: slot_q <= dum_q - 1'b1;
                                    PH_RXD: slot_q <= DUM_W'(slot_last(plan.dat));
                                    default: ;
                                endcase
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qseq_shift.sv
module qseq_shift
    import qseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [BYTE_W-1:0]   load_val,
    input  logic                shift_en,
    input  logic                cap_en,
    input  logic                cap_last,
    input  lane_cnt_t           lanes,
    input  logic                drive,
    input  logic [LANE_N-1:0]   dq_i,
    output logic [LANE_N-1:0]   dq_o,
    output logic [LANE_N-1:0]   dq_oe,
    output logic                rx_valid,
    output logic [BYTE_W-1:0]   rx_data
);
    logic [BYTE_W-1:0] tx_sh, rx_sh, rx_nxt;

    always_comb begin
        case (lanes)
            3'd2: begin
                dq_o   = {2'b00, tx_sh[BYTE_W-1 -: 2]};
                rx_nxt = {rx_sh[BYTE_W-3:0], dq_i[1:0]};
            end
            3'd4: begin
                dq_o   = tx_sh[BYTE_W-1 -: LANE_N];
                rx_nxt = {rx_sh[BYTE_W-5:0], dq_i};
            end
            default: begin
                dq_o   = {3'b000, tx_sh[BYTE_W-1]};
                rx_nxt = {rx_sh[BYTE_W-2:0], dq_i[1]};
            end
        endcase
    end

    assign dq_oe = drive ? lane_mask(lanes) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            if (load_en)
                tx_sh <= load_val;
            else if (shift_en)
                tx_sh <= tx_sh << lanes;
            rx_valid <= cap_last;
            if (cap_en)
                rx_sh <= rx_nxt;
            if (cap_last)
                rx_data <= rx_nxt;
        end
    end
endmodule

// File: rtl/qseq_engine.sv
module qseq_engine
    import qseq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DUM_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                start,
    input  logic [2:0]          fmt,
    input  logic [1:0]          addr_mode,
    input  logic [31:0]         addr,
    input  logic [7:0]          opcode,
    input  logic [DUM_W-1:0]    dummy_cycles,
    input  logic [CNT_W-1:0]    tx_count,
    input  logic [CNT_W-1:0]    rx_count,
    input  logic                tx_valid,
    input  logic [7:0]          tx_data,
    output logic                tx_ready,
    output logic                rx_valid,
    output logic [7:0]          rx_data,
    output logic                busy,
    output logic                tx_done,
    output logic                rx_done,
    output logic                cs_n,
    output logic                sck,
    output logic [3:0]          dq_o,
    output logic [3:0]          dq_oe,
    input  logic [3:0]          dq_i
);
    phase_e             phase;
    lane_cnt_t          lanes;
    logic               drive, load_en, shift_en, cap_en, cap_last;
    logic [BYTE_W-1:0]  load_val;

    qseq_fsm #(.CNT_W(CNT_W), .DUM_W(DUM_W)) fsm_i (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .fmt(fmt),
        .addr_mode(addr_mode), .addr(addr), .opcode(opcode),
        .dummy_cycles(dummy_cycles), .tx_count(tx_count), .rx_count(rx_count),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .busy(busy), .cs_n(cs_n), .sck(sck), .tx_done(tx_done),
        .rx_done(rx_done), .phase(phase), .lanes(lanes), .drive(drive),
        .load_en(load_en), .load_val(load_val), .shift_en(shift_en),
        .cap_en(cap_en), .cap_last(cap_last)
    );

    qseq_shift shift_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
        .shift_en(shift_en), .cap_en(cap_en), .cap_last(cap_last),
        .lanes(lanes), .drive(drive), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // R10
    sck_cs_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n);
    // R10
    sck_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sck));
    // R5
    dq_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUM || phase == PH_RXD || cs_n) |-> (dq_oe == 4'b0000));
    // R1
    oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(dq_oe + 4'd1) <= 1);
    // R7
    rx_done_pair_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> rx_valid);
    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> busy);
    // R8
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_n && start) |=> busy);
endmodule

// File: tb/qseq_engine_tb_top.sv
module qseq_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  fmt = '0;
    logic [1:0]  addr_mode = '0;
    logic [31:0] addr = '0;
    logic [7:0]  opcode = '0;
    logic [7:0]  dummy_cycles = '0;
    logic [15:0] tx_count = '0, rx_count = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_ready, rx_valid, busy, tx_done, rx_done, cs_n, sck;
    logic [7:0]  rx_data;
    logic [3:0]  dq_o, dq_oe;
    logic [3:0]  dq_i = '0;

    always #5 clk = ~clk;

    qseq_engine dut_i (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .fmt(fmt),
        .addr_mode(addr_mode), .addr(addr), .opcode(opcode),
        .dummy_cycles(dummy_cycles), .tx_count(tx_count), .rx_count(rx_count),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
        .tx_done(tx_done), .rx_done(rx_done), .cs_n(cs_n), .sck(sck),
        .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    int errors = 0, checks = 0;
    int period = 2, tcnt = 0;
    int valid_pct = 100;

    logic [7:0] txb [16];
    int         txi = 0;
    assign tx_data = txb[txi[3:0]];

    // free-running divider strobe
    always @(posedge clk) begin
        if (tcnt >= period - 1) begin tick <= 1'b1; tcnt <= 0; end
        else begin tick <= 1'b0; tcnt <= tcnt + 1; end
    end

    // transmit source with random gaps
    always @(posedge clk) begin
        if (tx_valid && tx_ready) txi <= txi + 1;
        tx_valid <= (($urandom % 100) < valid_pct);
    end

    // bus recorder and flash model
    logic [3:0] obs_oe [256], obs_do [256], drv [256];
    logic [7:0] rxb [64];
    int pos, drv_slot, cs_falls, txd_cnt, txd_pos, rxd_cnt, rxd_pos, rxv_cnt;
    int gap_cyc, bad_sck, stall_rise;
    logic sck_p = 1'b0, tick_p = 1'b0, cs_p = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (sck && !sck_p) begin
                if (pos < 256) begin obs_oe[pos] = dq_oe; obs_do[pos] = dq_o; end
                pos++;
            end
            if (sck != sck_p && !tick_p) bad_sck++;
            if (tx_ready && sck) stall_rise++;
            if (cs_p && !cs_n) cs_falls++;
            if (!sck && drv_slot != pos && pos < 256) begin
                dq_i = 4'($urandom);
                drv[pos] = dq_i;
                drv_slot = pos;
            end
            if (tx_done) begin txd_cnt++; txd_pos = pos; end
            if (rx_done) begin rxd_cnt++; rxd_pos = pos; end
            if (rx_valid) begin
                if (rxv_cnt < 64) rxb[rxv_cnt] = rx_data;
                rxv_cnt++;
            end
            if (cs_n && busy) gap_cyc++;
        end
        sck_p = sck; tick_p = tick; cs_p = cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // independent model of the line plan: which 0 command, 1 address, 2 data
    function automatic int lanes_of(input int code, input int which);
        if (which == 0) return (code == 7) ? 4 : (code == 6) ? 2 : 1;
        if (which == 1) return (code == 5 || code == 7) ? 4 :
                               (code == 4 || code == 6) ? 2 : 1;
        return (code == 3 || code == 5 || code == 7) ? 4 :
               (code == 2 || code == 4 || code == 6) ? 2 : 1;
    endfunction

    function automatic int lmask(input int l);
        return (l == 4) ? 15 : (l == 2) ? 3 : 1;
    endfunction

    logic [3:0] exp_oe [256], exp_bits [256];
    int         exp_kind [256];
    int         ek;

    task automatic push_byte(input logic [7:0] b, input int l);
        for (int k = 0; k < 8 / l; k++) begin
            exp_oe[ek]   = 4'(lmask(l));
            exp_bits[ek] = 4'((b >> (8 - l * (k + 1))) & lmask(l));
            exp_kind[ek] = 0;
            ek++;
        end
    endtask

    task automatic push_quiet(input int n, input int kind);
        for (int k = 0; k < n; k++) begin
            exp_oe[ek] = '0; exp_bits[ek] = '0; exp_kind[ek] = kind; ek++;
        end
    endtask

    task automatic run_txn(input int code, input int am, input logic [31:0] a,
                           input logic [7:0] op, input int dum, input int ntx,
                           input int nrx, input int per, input bit probe,
                           input string tag);
        int lo, la, ld, alen, rx0, out_end, bad_out, bad_dum, bad_rx, wd;
        lo = lanes_of(code, 0); la = lanes_of(code, 1); ld = lanes_of(code, 2);
        alen = (am == 1) ? 3 : (am == 2) ? 4 : 0;
        period = per;
        for (int i = 0; i < 16; i++) txb[i] = 8'($urandom);
        txi = 0;
        @(negedge clk);
        pos = 0; drv_slot = -1; cs_falls = 0; txd_cnt = 0; txd_pos = -1;
        rxd_cnt = 0; rxd_pos = -1; rxv_cnt = 0; gap_cyc = 0; bad_sck = 0;
        stall_rise = 0;
        fmt = 3'(code); addr_mode = 2'(am); addr = a; opcode = op;
        dummy_cycles = 8'(dum); tx_count = 16'(ntx); rx_count = 16'(nrx);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (probe) begin
            repeat (4 * per + 3) @(negedge clk);
            fmt = ~fmt; opcode = ~op; rx_count = 16'd9; tx_count = 16'd7;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (busy && wd < 20000) begin @(negedge clk); wd++; end
        chk(wd < 20000, "R9 busy release", wd, 0);

        // expected bus trace
        ek = 0;
        push_byte(op, lo);
        for (int i = alen - 1; i >= 0; i--) push_byte(8'(a >> (8 * i)), la);
        push_quiet(dum, 1);
        for (int i = 0; i < ntx; i++) push_byte(txb[i], ld);
        out_end = (ntx > 0) ? ek : 8 / lo + alen * 8 / la;
        rx0 = ek;
        push_quiet(nrx * 8 / ld, 2);

        bad_out = 0; bad_dum = 0; bad_rx = 0;
        for (int s = 0; s < ek && s < pos && s < 256; s++) begin
            if (exp_kind[s] == 0) begin
                if (obs_oe[s] != exp_oe[s] || (obs_do[s] & obs_oe[s]) != exp_bits[s])
                    bad_out++;
            end else if (obs_oe[s] != 0) begin
                if (exp_kind[s] == 1) bad_dum++; else bad_rx++;
            end
        end
        chk(pos == ek, {tag, " R3 clock count"}, pos, ek);
        chk(bad_out == 0, {tag, " R1 R2 R4 output lanes"}, bad_out, 0);
        chk(bad_dum == 0 && bad_rx == 0, {tag, " R5 released lines"}, bad_dum + bad_rx, 0);
        chk(txd_cnt == 1 && txd_pos == out_end, {tag, " R6 tx_done position"}, txd_pos, out_end);
        chk(rxd_cnt == ((nrx > 0) ? 1 : 0), {tag, " R7 rx_done count"}, rxd_cnt, (nrx > 0) ? 1 : 0);
        if (nrx > 0)
            chk(rxd_pos == ek, {tag, " R7 rx_done position"}, rxd_pos, ek);
        chk(rxv_cnt == nrx, {tag, " R7 rx byte count"}, rxv_cnt, nrx);
        for (int j = 0; j < nrx && j < rxv_cnt; j++) begin
            logic [7:0] e;
            e = '0;
            for (int k = 0; k < 8 / ld; k++) begin
                int s;
                s = rx0 + j * (8 / ld) + k;
                e = (ld == 1) ? {e[6:0], drv[s][1]} : 8'((e << ld) | (drv[s] & 4'(lmask(ld))));
            end
            chk(rxb[j] == e, {tag, " R2 R7 rx byte"}, rxb[j], e);
        end
        chk(gap_cyc == per && cs_n, {tag, " R9 deselect gap"}, gap_cyc, per);
        chk(cs_falls == 1, {tag, " R8 single selection"}, cs_falls, 1);
        chk(bad_sck == 0 && !sck, {tag, " R10 clock on ticks"}, bad_sck, 0);
        chk(txi == ntx && stall_rise == 0, {tag, " R11 transmit handshake"}, txi, ntx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5eed01));
        repeat (5) @(negedge clk);
        // R12 reset state
        chk(cs_n && !sck && !busy && dq_oe == 0 && !tx_ready && !rx_valid
            && !tx_done && !rx_done, "R12 reset outputs", {cs_n, sck, busy}, 3'b100);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // directed corners
        run_txn(0, 0, 32'h0, 8'h9F, 0, 0, 3, 2, 0, "id-read R4");
        run_txn(7, 2, 32'hA1B2C3D4, 8'hEB, 6, 2, 4, 1, 0, "quad-full R1");
        run_txn(1, 1, 32'h00123456, 8'h02, 0, 3, 0, 3, 0, "code1 tx-only R6");
        run_txn(5, 1, 32'h00FEDCBA, 8'hEC, 2, 0, 2, 2, 0, "quad-addr");
        run_txn(3, 3, 32'h55AA55AA, 8'h6B, 8, 0, 1, 1, 0, "spare-addr R4");
        run_txn(6, 2, 32'h01020304, 8'h3C, 0, 1, 1, 2, 1, "busy-start R8");
        valid_pct = 40;
        run_txn(4, 1, 32'h00C0FFEE, 8'h38, 1, 5, 0, 1, 0, "stall R11");
        // constrained random
        for (int n = 0; n < 50; n++) begin
            valid_pct = 30 + int'($urandom % 71);
            run_txn(int'($urandom % 8), int'($urandom % 4), $urandom,
                    8'($urandom), int'($urandom % 7), int'($urandom % 6),
                    int'($urandom % 6), 1 + int'($urandom % 3),
                    bit'($urandom % 2), "random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule